// File: doc/BRIEF.md
# Two-Level Carry-Lookahead 32-Bit Adder

This block adds two 32-bit operands and a carry-in without rippling a carry through the bits. Every bit first forms a generate and a propagate term from its two operand bits. Nibble-wide slices reduce these terms to a group generate and a group propagate. A lookahead unit turns the group terms of four slices, together with the section carry-in, into every slice carry-in at once. Two 16-bit sections are joined by one more lookahead unit of the same kind. That unit yields the carry into the upper section, the final carry-out, and a group generate/propagate pair for the whole word.

The outputs are the sum, the carry-out and a signed overflow flag. The word-level generate and propagate are also brought out, so a wider adder can cascade this one under a further lookahead level. The whole block is combinational.

Top module: `cla_adder32`

## Requirements
- R1: `sum` equals the low 32 bits of op_a + op_b + carry_in, with the operands taken as unsigned.
- R2: `carry_out` is bit 32 of the 33-bit unsigned result of op_a + op_b + carry_in.
- R3: `overflow` is 1 exactly when op_a[31] equals op_b[31] and sum[31] differs from them. Equivalently, the two's-complement sum of the operands and carry_in lies outside the range -2^31 to 2^31-1.
- R4: `grp_prop` is 1 exactly when op_a XOR op_b has all 32 bits set.
- R5: `grp_gen` is 1 exactly when op_a + op_b, with no carry-in, carries out of bit 31. `grp_gen` and `grp_prop` are never 1 together.
- R6: When `grp_prop` is 1, the carry-in passes through all eight slices and both sections. The result is sum = 0 and carry_out = 1 for carry_in = 1, and sum = all ones and carry_out = 0 for carry_in = 0.
- R7: `grp_gen` and `grp_prop` depend only on op_a and op_b. Toggling carry_in with the operands held leaves both unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First addend |
| op_b | input | 32 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 32 | Sum modulo 2^32 |
| carry_out | output | 1 | Carry out of bit 31 |
| overflow | output | 1 | Signed overflow of the addition |
| grp_gen | output | 1 | Word-level generate for a higher lookahead level |
| grp_prop | output | 1 | Word-level propagate for a higher lookahead level |

## Verification
The hardest case to reach from the ports is a carry that must travel the full width: every bit propagates, so carry_in alone decides all 32 sum bits and the carry-out. Uniform random operands hit this with probability 2^-32. The stimulus therefore often sets op_b to the complement of op_a, sometimes with a few bits flipped back so that only a single slice or section stops the chain. It also drives both carry_in values on the same operands to show that the group terms ignore the carry-in.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Per-bit carry generate: both operand bits set.
  function automatic logic bit_generate(input logic a, input logic b);
    return a & b;
  endfunction

  // Per-bit carry propagate: exactly one operand bit set.
  function automatic logic bit_propagate(input logic a, input logic b);
    return a ^ b;
  endfunction

  // Sum bit from the propagate term and the incoming carry.
  function automatic logic bit_sum(input logic p, input logic c);
    return p ^ c;
  endfunction

  // Signed overflow from the carry into and out of the sign bit.
  function automatic logic sign_overflow(input logic carry_into_msb, input logic carry_from_msb);
    return carry_into_msb ^ carry_from_msb;
  endfunction

endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin,
  output logic [N-1:0] carry_grp,
  output logic         carry_out,
  output logic         gen_all,
  output logic         prop_all
);

  // Carry into position k, k = 0..N; position 0 is the incoming carry.
  logic [N:0] carry_vec;

  // Each carry is a flat sum of products of generate/propagate terms and cin.
  always_comb begin
    logic term;
    carry_vec[0] = cin;
    for (int k = 1; k <= N; k++) begin
      carry_vec[k] = 1'b0;
      for (int j = -1; j < k; j++) begin
        term = (j < 0) ? cin : gen_i[j];
        for (int m = j + 1; m < k; m++) begin
          term = term & prop_i[m];
        end
        carry_vec[k] = carry_vec[k] | term;
      end
    end
  end

  // Group generate and propagate for the level above.
  always_comb begin
    logic term;
    gen_all = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = gen_i[j];
      for (int m = j + 1; m < N; m++) begin
        term = term & prop_i[m];
      end
      gen_all = gen_all | term;
    end
    prop_all = &prop_i;
  end

  assign carry_grp = carry_vec[N-1:0];
  assign carry_out = carry_vec[N];

  // A fully propagating group hands the carry straight through (R6).
  always_comb begin
    if (prop_all) begin
      assert_pass_through_R6: assert (carry_out == cin)
        else $error("lookahead: propagating group altered the carry");
    end
  end

  // Exclusive inputs give exclusive group terms (R5).
  always_comb begin
    if ((gen_i & prop_i) == '0) begin
      assert_gp_exclusive_R5: assert (!(gen_all && prop_all))
        else $error("lookahead: group generate and propagate both set");
    end
  end

endmodule

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] x,
  input  logic [SLICE_W-1:0] y,
  input  logic               cin,
  output logic [SLICE_W-1:0] s,
  output logic               gen_grp,
  output logic               prop_grp
);

  logic [SLICE_W-1:0] bit_g;
  logic [SLICE_W-1:0] bit_p;
  logic [SLICE_W-1:0] bit_c;
  logic               slice_cout;

  // Stage 1: per-bit terms from the operands only.
  for (genvar i = 0; i < SLICE_W; i++) begin : g_bits
    assign bit_g[i] = bit_generate(x[i], y[i]);
    assign bit_p[i] = bit_propagate(x[i], y[i]);
  end

  // Stage 2: group terms and internal carries.
  cla_lookahead #(.N(SLICE_W)) u_la (
    .gen_i    (bit_g),
    .prop_i   (bit_p),
    .cin      (cin),
    .carry_grp(bit_c),
    .carry_out(slice_cout),
    .gen_all  (gen_grp),
    .prop_all (prop_grp)
  );

  // Stage 3: sums.
  for (genvar i = 0; i < SLICE_W; i++) begin : g_sum
    assign s[i] = bit_sum(bit_p[i], bit_c[i]);
  end

  // Slice result matches plain addition (R1).
  always_comb begin
    logic [SLICE_W:0] ref_sum;
    ref_sum = {1'b0, x} + {1'b0, y} + {{SLICE_W{1'b0}}, cin};
    assert_slice_sum_R1: assert ({slice_cout, s} == ref_sum)
      else $error("slice: sum mismatch");
  end

endmodule

// File: rtl/cla_section.sv
module cla_section #(
  parameter int SECTION_W = 16,
  parameter int SLICE_W   = 4
) (
  input  logic [SECTION_W-1:0] x,
  input  logic [SECTION_W-1:0] y,
  input  logic                 cin,
  output logic [SECTION_W-1:0] s,
  output logic                 gen_grp,
  output logic                 prop_grp
);

  localparam int SLICES = SECTION_W / SLICE_W;

  logic [SLICES-1:0] sl_gen;
  logic [SLICES-1:0] sl_prop;
  logic [SLICES-1:0] sl_cin;
  logic              sec_cout;

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    cla_slice #(.SLICE_W(SLICE_W)) u_slice (
      .x       (x[k*SLICE_W +: SLICE_W]),
      .y       (y[k*SLICE_W +: SLICE_W]),
      .cin     (sl_cin[k]),
      .s       (s[k*SLICE_W +: SLICE_W]),
      .gen_grp (sl_gen[k]),
      .prop_grp(sl_prop[k])
    );
  end

  // Slice group terms return as slice carry-ins, all in parallel.
  cla_lookahead #(.N(SLICES)) u_la (
    .gen_i    (sl_gen),
    .prop_i   (sl_prop),
    .cin      (cin),
    .carry_grp(sl_cin),
    .carry_out(sec_cout),
    .gen_all  (gen_grp),
    .prop_all (prop_grp)
  );

  // Section carry-out agrees with plain addition (R2).
  always_comb begin
    logic [SECTION_W:0] ref_sum;
    ref_sum = {1'b0, x} + {1'b0, y} + {{SECTION_W{1'b0}}, cin};
    assert_section_carry_R2: assert (sec_cout == ref_sum[SECTION_W])
      else $error("section: carry-out mismatch");
  end

endmodule

// File: rtl/cla_adder32.sv
module cla_adder32
  import cla_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int SECTION_W = 16,
  parameter int SLICE_W   = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             overflow,
  output logic             grp_gen,
  output logic             grp_prop
);

  localparam int NSEC = WIDTH / SECTION_W;

  logic [NSEC-1:0] sec_gen;
  logic [NSEC-1:0] sec_prop;
  logic [NSEC-1:0] sec_cin;
  logic            msb_carry_in;

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    cla_section #(.SECTION_W(SECTION_W), .SLICE_W(SLICE_W)) u_sec (
      .x       (op_a[k*SECTION_W +: SECTION_W]),
      .y       (op_b[k*SECTION_W +: SECTION_W]),
      .cin     (sec_cin[k]),
      .s       (sum[k*SECTION_W +: SECTION_W]),
      .gen_grp (sec_gen[k]),
      .prop_grp(sec_prop[k])
    );
  end

  // Top level: joins the sections and yields the word carry-out.
  cla_lookahead #(.N(NSEC)) u_la (
    .gen_i    (sec_gen),
    .prop_i   (sec_prop),
    .cin      (carry_in),
    .carry_grp(sec_cin),
    .carry_out(carry_out),
    .gen_all  (grp_gen),
    .prop_all (grp_prop)
  );

  // Carry into the sign bit recovered from the sign-bit sum.
  assign msb_carry_in = bit_sum(bit_propagate(op_a[WIDTH-1], op_b[WIDTH-1]), sum[WIDTH-1]);
  assign overflow     = sign_overflow(msb_carry_in, carry_out);

  always_comb begin
    logic [WIDTH:0] ref_sum;
    ref_sum = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    assert_word_sum_R1: assert (sum == ref_sum[WIDTH-1:0])
      else $error("adder: sum mismatch");
    assert_word_carry_R2: assert (carry_out == ref_sum[WIDTH])
      else $error("adder: carry-out mismatch");
    assert_no_overflow_R3: assert (overflow ==
        ((op_a[WIDTH-1] == op_b[WIDTH-1]) && (sum[WIDTH-1] != op_a[WIDTH-1])))
      else $error("adder: overflow flag mismatch");
    assert_full_prop_R4: assert (grp_prop == ((op_a ^ op_b) == '1))
      else $error("adder: word propagate mismatch");
  end

endmodule

// File: tb/sim_cla_adder32.sv
module sim_cla_adder32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [31:0] sum;
  logic        carry_out;
  logic        overflow;
  logic        grp_gen;
  logic        grp_prop;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cla_adder32 u0 (
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .sum      (sum),
    .carry_out(carry_out),
    .overflow (overflow),
    .grp_gen  (grp_gen),
    .grp_prop (grp_prop)
  );

  task automatic expect_eq(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h ci=%b)", tag, act, exp, op_a, op_b, carry_in);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic ci);
    @(posedge clk);
    #1;
    op_a = a; op_b = b; carry_in = ci;
    @(negedge clk);
  endtask

  // Expected results from integer arithmetic, checked on every vector.
  task automatic run_vec(input logic [31:0] a, input logic [31:0] b, input logic ci);
    longint unsigned usum;
    longint          ssum;
    logic            exp_ovf;
    logic            exp_gen;
    apply(a, b, ci);
    usum    = longint'(a) + longint'(b) + longint'(ci);
    ssum    = longint'($signed(a)) + longint'($signed(b)) + longint'(ci);
    exp_ovf = (ssum > 64'sd2147483647) || (ssum < -64'sd2147483648);
    exp_gen = ((longint'(a) + longint'(b)) >= 64'd4294967296);
    expect_eq("R1 sum", {1'b0, sum}, {1'b0, usum[31:0]});
    expect_eq("R2 carry_out", {32'd0, carry_out}, {32'd0, usum[32]});
    expect_eq("R3 overflow", {32'd0, overflow}, {32'd0, exp_ovf});
    expect_eq("R4 grp_prop", {32'd0, grp_prop}, {32'd0, ((a ^ b) == 32'hffff_ffff)});
    expect_eq("R5 grp_gen", {32'd0, grp_gen}, {32'd0, exp_gen});
  endtask

  // R7: group terms must not move when only carry_in toggles.
  task automatic cin_independence(input logic [31:0] a, input logic [31:0] b);
    logic g0, p0;
    apply(a, b, 1'b0);
    g0 = grp_gen; p0 = grp_prop;
    apply(a, b, 1'b1);
    expect_eq("R7 grp_gen vs carry_in", {32'd0, grp_gen}, {32'd0, g0});
    expect_eq("R7 grp_prop vs carry_in", {32'd0, grp_prop}, {32'd0, p0});
  endtask

  initial begin
    logic [31:0] ra, rb;
    void'($urandom(32'h1357_9bdf));
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Idle state: zero operands give zero everywhere.
    @(negedge clk);
    expect_eq("R1 idle sum", {1'b0, sum}, 33'd0);
    expect_eq("R2 idle carry", {32'd0, carry_out}, 33'd0);

    run_vec(32'h0000_0000, 32'h0000_0000, 1'b0);
    run_vec(32'hffff_ffff, 32'h0000_0001, 1'b0);
    run_vec(32'h7fff_ffff, 32'h0000_0001, 1'b0);   // R3 positive overflow
    run_vec(32'h8000_0000, 32'h8000_0000, 1'b0);   // R3 negative overflow
    run_vec(32'h8000_0000, 32'h7fff_ffff, 1'b1);   // R3 mixed signs
    run_vec(32'h7fff_ffff, 32'h0000_0000, 1'b1);   // R3 overflow from carry_in alone
    run_vec(32'h0000_ffff, 32'h0000_0001, 1'b0);   // carry crossing the sections
    run_vec(32'h0000_000f, 32'h0000_0001, 1'b0);   // carry crossing one slice

    // R6: full propagate chain, carry_in decides everything.
    run_vec(32'hffff_0000, 32'h0000_ffff, 1'b1);
    expect_eq("R6 chain sum", {1'b0, sum}, 33'd0);
    expect_eq("R6 chain carry", {32'd0, carry_out}, 33'd1);
    run_vec(32'ha5a5_5a5a, 32'h5a5a_a5a5, 1'b0);
    expect_eq("R6 chain sum no cin", {1'b0, sum}, {1'b0, 32'hffff_ffff});
    expect_eq("R6 chain carry no cin", {32'd0, carry_out}, 33'd0);

    cin_independence(32'h1234_5678, 32'hedcb_a987);
    cin_independence(32'hffff_ffff, 32'hffff_ffff);

    for (int i = 0; i < 400; i++) begin
      ra = $urandom();
      case ($urandom() % 4)
        0: rb = ~ra;
        1: rb = ~ra ^ (32'h1 << ($urandom() % 32));
        default: rb = $urandom();
      endcase
      run_vec(ra, rb, 1'($urandom() % 2));
      if (i % 50 == 0) cin_independence(ra, rb);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule